// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the processor side of one transfer on a bus where address and data share the same lines. The core presents a request with an address, a direction, a memory or I/O selector, a byte-high enable and write data. The sequencer then walks a fixed chain of clock states, T1, T2, T3, optional TW wait states, and T4. Each state lasts one clock. Idle states (Ti) fill the gaps when the core has nothing to send.

The block drives the address latch pulse and the read, write and interrupt-acknowledge strobes. It also drives the data-direction and data-enable controls for external transceivers, and the output enable of the shared lines. In T1 the lines carry the low address bits and the latch pulse is high, so external latches capture the address on its falling edge. From T2 on, the lines carry write data, or they float so that read data can come in.

The ready input is active high and is assumed to be synchronous already. It stretches the transfer one wait state at a time. An interrupt-acknowledge request runs as two back-to-back cycles with the shared lines floating, and it returns the type byte read on the low eight data lines.

Top module: `mbus_seq`

## Requirements
- R1: While rst_ni is low, and right after it rises, the sequencer is idle: ale_o=0, rd_n_o=wr_n_o=inta_n_o=1, ad_oe_o=0, den_n_o=1, dt_r_n_o=1, done_o=0, mio_o=0.
- R2: In an idle state, req_i=1 raises req_ack_o in the same cycle, and T1 starts at the next clock edge. With req_i=0 the block stays idle and does not drive the bus.
- R3: In T1, ale_o=1 for exactly that one cycle. For any cycle other than interrupt acknowledge, the block also does the following in T1: ad_oe_o=1, ad_o equals address bits [DATA_W-1:0], a_hi_o equals the upper address bits, and bhe_n_o equals req_bhe_n_i. All strobes stay inactive in T1. bhe_n_o=0 with address bit 0 = 0 selects the word, bhe_n_o=0 with bit 0 = 1 selects the high byte, and bhe_n_o=1 with bit 0 = 0 selects the low byte.
- R4: In a read (req_write_i=0), rd_n_o is low from T2 through the last T3/TW state and high in T4. In T2 through T4: ad_oe_o=0 and dt_r_n_o=0. den_n_o is low from T2 through the last T3/TW state.
- R5: In a write (req_write_i=1), wr_n_o is low from T2 through the last T3/TW state and high in T4. From T2 through T4: ad_o equals the write data, ad_oe_o=1, dt_r_n_o=1 and den_n_o=0.
- R6: ready_i is sampled only at the clock edge that ends T3 and at the edge that ends each TW. A low sample inserts another TW, and a high sample moves the cycle to T4. The value of ready_i during T2 has no effect.
- R7: rdata_o holds ad_i as sampled on the edge that ends the last T3/TW state. done_o is high for the single cycle T4 of every read or write.
- R8: A request with req_inta_i=1 runs two back-to-back cycles. The second T1 follows the first T4 with no idle state and no new request. In both cycles, inta_n_o is low from T2 through the last T3/TW state and ad_oe_o stays 0. done_o rises only in the T4 of the second cycle, and rdata_o then holds the low byte taken in that second cycle, zero-extended.
- R9: mio_o is 1 from T1 through T4 for a memory cycle, and 0 for an I/O cycle and for interrupt acknowledge.
- R10: If req_i=1 during T4 of a cycle that ends a transfer, req_ack_o=1 in that T4 and the next state is T1, with no idle state in between.
- R11: Pulling rst_ni low in the middle of a cycle returns every strobe and bus control to its R1 idle value immediately, and the block stays idle after rst_ni rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core requests a bus cycle |
| req_addr_i | input | ADDR_W | Cycle address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_inta_i | input | 1 | Run a two-cycle interrupt acknowledge |
| req_bhe_n_i | input | 1 | Byte-high enable for the cycle, active low |
| req_wdata_i | input | DATA_W | Write data |
| req_ack_o | output | 1 | Request taken this cycle |
| done_o | output | 1 | One-cycle pulse in the final T4 |
| rdata_o | output | DATA_W | Captured read data or type byte |
| ready_i | input | 1 | Synchronized ready, active high |
| ad_i | input | DATA_W | Shared bus, incoming value |
| ad_o | output | DATA_W | Shared bus, outgoing value |
| ad_oe_o | output | 1 | Drive enable for the shared bus |
| a_hi_o | output | ADDR_W-DATA_W | Upper address bits, valid in T1 |
| ale_o | output | 1 | Address latch pulse |
| bhe_n_o | output | 1 | Byte-high enable, valid in T1 |
| mio_o | output | 1 | 1 = memory cycle |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt-acknowledge strobe, active low |
| dt_r_n_o | output | 1 | Transceiver direction, 1 = transmit |
| den_n_o | output | 1 | Transceiver enable, active low |

## Verification
The hardest situation to reach is the hand-off inside an interrupt acknowledge: the second T1 must follow the first T4 on its own, with req_i already low, and the type byte must come from the second cycle only. The stimulus therefore puts a decoy value on ad_i during the first acknowledge cycle and a different value during the second. It also stretches both cycles with a wait state, so a capture at the wrong edge or in the wrong cycle shows up on rdata_o. Further directed runs keep req_i high through a T4 to force the back-to-back path, hold ready_i low during every T2, and pull reset low in the middle of a waited write.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_TI = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_TW = 3'd4,
    ST_T4 = 3'd5
  } bus_state_e;

  typedef struct packed {
    logic write;
    logic io;
    logic inta;
    logic bhe_n;
  } cyc_kind_t;
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_inta_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       start_o,
  output logic       capture_o,
  output logic       done_o
);
  bus_state_e state_q, state_d;
  logic       inta_first_q;

  // a new request is taken from idle, or from the T4 that closes a transfer
  assign start_o   = req_i && (state_q == ST_TI || (state_q == ST_T4 && !inta_first_q));
  assign capture_o = (state_q == ST_T3 || state_q == ST_TW) && ready_i;
  assign done_o    = (state_q == ST_T4) && !inta_first_q;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TI: if (start_o) state_d = ST_T1;
      ST_T1: state_d = ST_T2;
      ST_T2: state_d = ST_T3;
      ST_T3, ST_TW: state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4: state_d = (inta_first_q || start_o) ? ST_T1 : ST_TI;
      default: state_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_TI;
      inta_first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o)                inta_first_q <= req_inta_i;
      else if (state_q == ST_T4)  inta_first_q <= 1'b0;
    end
  end

  // R3
  t1_then_t2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T1) |=> (state_q == ST_T2));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  ready_low_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_T3 || state_q == ST_TW) && !ready_i) |=> (state_q == ST_TW));
endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_inta_i,
  input  logic              req_bhe_n_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output cyc_kind_t         kind_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int TYPE_W = 8;

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      kind_o  <= '{write: 1'b0, io: 1'b0, inta: 1'b0, bhe_n: 1'b1};
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
        kind_o  <= '{write: req_write_i && !req_inta_i, io: req_io_i,
                     inta: req_inta_i, bhe_n: req_bhe_n_i};
      end
      if (capture_i) rdata_q <= ad_i;
    end
  end

  // the type byte arrives on the low lanes only
  assign rdata_o = kind_o.inta ? {{(DATA_W-TYPE_W){1'b0}}, rdata_q[TYPE_W-1:0]} : rdata_q;
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  cyc_kind_t         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              bhe_n_o,
  output logic              mio_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              dt_r_n_o,
  output logic              den_n_o
);
  logic in_t1, strobe_win, in_t4, in_cyc, addr_ph;

  assign in_t1      = (state_i == ST_T1);
  assign in_t4      = (state_i == ST_T4);
  assign strobe_win = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign in_cyc     = (state_i != ST_TI);
  assign addr_ph    = in_t1 && !kind_i.inta;

  assign ale_o    = in_t1;
  assign rd_n_o   = !(strobe_win && !kind_i.write && !kind_i.inta);
  assign wr_n_o   = !(strobe_win && kind_i.write);
  assign inta_n_o = !(strobe_win && kind_i.inta);

  assign ad_oe_o  = addr_ph || (kind_i.write && (strobe_win || in_t4));
  assign ad_o     = addr_ph ? addr_i[DATA_W-1:0] : (ad_oe_o ? wdata_i : '0);
  assign a_hi_o   = addr_ph ? addr_i[ADDR_W-1:DATA_W] : '0;
  assign bhe_n_o  = addr_ph ? kind_i.bhe_n : 1'b1;
  assign mio_o    = in_cyc && !kind_i.io && !kind_i.inta;

  assign dt_r_n_o = in_cyc ? kind_i.write : 1'b1;
  assign den_n_o  = !(strobe_win || (in_t4 && kind_i.write));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  // R8
  inta_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_n_o |-> !ad_oe_o);
  // R3
  ale_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o && rd_n_o == 1'b0 || wr_n_o == 1'b0 || inta_n_o == 1'b0);
  // R5
  wr_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |=> ad_oe_o);
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_inta_i,
  input  logic              req_bhe_n_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              bhe_n_o,
  output logic              mio_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              dt_r_n_o,
  output logic              den_n_o
);
  bus_state_e        state;
  logic              start, capture;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  cyc_kind_t         kind;

  assign req_ack_o = start;

  mbus_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_i, .req_inta_i, .ready_i,
    .state_o(state), .start_o(start), .capture_o(capture), .done_o(done_o)
  );

  mbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i, .rst_ni, .start_i(start), .capture_i(capture),
    .req_addr_i, .req_write_i, .req_io_i, .req_inta_i, .req_bhe_n_i, .req_wdata_i,
    .ad_i, .addr_o(addr), .wdata_o(wdata), .kind_o(kind), .rdata_o(rdata_o)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk_i, .rst_ni, .state_i(state), .kind_i(kind), .addr_i(addr), .wdata_i(wdata),
    .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .bhe_n_o, .mio_o,
    .rd_n_o, .wr_n_o, .inta_n_o, .dt_r_n_o, .den_n_o
  );

  // R10
  ack_idle_or_t4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> ale_o);
endmodule

// File: tb/sim_mbus_seq.sv
module sim_mbus_seq;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef struct packed {
    logic              write;
    logic              io;
    logic              inta;
    logic              bhe_n;
    logic [2:0]        waits;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] bus;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 20'hA5F30, 16'h0000, 16'h1234},
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 20'h3C002, 16'hBEEF, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 20'h00081, 16'h0000, 16'h7E00},
    '{1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 20'h00FFE, 16'h55AA, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 20'h00000, 16'h0000, 16'hC3A7},
    '{1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 20'hFFFF0, 16'h0000, 16'h0F0F}
  };

  logic clk = 0, rst_ni = 0;
  logic req_i = 0, req_write_i = 0, req_io_i = 0, req_inta_i = 0, req_bhe_n_i = 1;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0, ad_i = '0;
  logic ready_i = 0;
  logic req_ack_o, done_o, ad_oe_o, ale_o, bhe_n_o, mio_o;
  logic rd_n_o, wr_n_o, inta_n_o, dt_r_n_o, den_n_o;
  logic [DATA_W-1:0] rdata_o, ad_o;
  logic [HI_W-1:0] a_hi_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mbus_seq u0 (
    .clk_i(clk), .rst_ni, .req_i, .req_addr_i, .req_write_i, .req_io_i, .req_inta_i,
    .req_bhe_n_i, .req_wdata_i, .req_ack_o, .done_o, .rdata_o, .ready_i, .ad_i,
    .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .bhe_n_o, .mio_o, .rd_n_o, .wr_n_o,
    .inta_n_o, .dt_r_n_o, .den_n_o
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string r);
    chk({ale_o, rd_n_o, wr_n_o, inta_n_o, ad_oe_o, den_n_o, dt_r_n_o, done_o, mio_o}
        == 9'b0_111_0_11_0_0, r,
        {ale_o, rd_n_o, wr_n_o, inta_n_o, ad_oe_o, den_n_o, dt_r_n_o, done_o, mio_o},
        9'b0_111_0_11_0_0);
  endtask

  // R4 R5 R8: strobe window T2..last T3/TW
  task automatic chk_mid(input vec_t v);
    logic [5:0] exp;
    exp = {!(!v.write && !v.inta), !v.write, !v.inta, v.write, v.write, 1'b0};
    chk({rd_n_o, wr_n_o, inta_n_o, ad_oe_o, dt_r_n_o, den_n_o} == exp,
        v.inta ? "R8 strobes" : (v.write ? "R5 strobes" : "R4 strobes"),
        {rd_n_o, wr_n_o, inta_n_o, ad_oe_o, dt_r_n_o, den_n_o}, exp);
    if (v.write) chk(ad_o == v.wdata, "R5 write data", ad_o, v.wdata);
  endtask

  task automatic run_txn(input vec_t v);
    int nph;
    nph = v.inta ? 2 : 1;
    @(negedge clk);
    req_i = 1; req_write_i = v.write; req_io_i = v.io; req_inta_i = v.inta;
    req_bhe_n_i = v.bhe_n; req_addr_i = v.addr; req_wdata_i = v.wdata; ready_i = 0;
    #1 chk(req_ack_o == 1'b1, "R2 ack", req_ack_o, 1);
    for (int p = 0; p < nph; p++) begin
      @(negedge clk); // T1
      req_i = 0;
      chk(ale_o == 1'b1, "R3 ale", ale_o, 1);
      chk(ad_oe_o == !v.inta, v.inta ? "R8 float T1" : "R3 drive T1", ad_oe_o, !v.inta);
      if (!v.inta) begin
        chk(ad_o == v.addr[DATA_W-1:0], "R3 addr lo", ad_o, v.addr[DATA_W-1:0]);
        chk(a_hi_o == v.addr[ADDR_W-1:DATA_W], "R3 addr hi", a_hi_o, v.addr[ADDR_W-1:DATA_W]);
        chk(bhe_n_o == v.bhe_n, "R3 bhe", bhe_n_o, v.bhe_n);
      end
      chk({rd_n_o, wr_n_o, inta_n_o} == 3'b111, "R3 strobes off", {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
      chk(mio_o == (!v.io && !v.inta), "R9 mio", mio_o, !v.io && !v.inta);
      ad_i = (p == nph - 1) ? v.bus : 16'h0011;
      ready_i = 0; // low in T2 must not add a wait (R6)
      @(negedge clk); // T2
      chk_mid(v);
      chk(ale_o == 1'b0, "R3 ale end", ale_o, 0);
      ready_i = (v.waits == 0);
      @(negedge clk); // T3
      chk_mid(v);
      for (int w = 0; w < int'(v.waits); w++) begin
        @(negedge clk); // TW
        chk_mid(v);
        chk(done_o == 1'b0, "R6 wait inserted", done_o, 0);
        ready_i = (w == int'(v.waits) - 1);
      end
      @(negedge clk); // T4
      chk({rd_n_o, wr_n_o, inta_n_o} == 3'b111, "R4 R5 strobes off T4", {rd_n_o, wr_n_o, inta_n_o}, 3'b111);
      chk(ad_oe_o == v.write, "R5 T4 drive", ad_oe_o, v.write);
      chk(mio_o == (!v.io && !v.inta), "R9 mio T4", mio_o, !v.io && !v.inta);
      chk(done_o == (p == nph - 1), v.inta ? "R8 done" : "R7 done", done_o, p == nph - 1);
      if (p == nph - 1 && !v.write) begin
        if (v.inta) chk(rdata_o == {8'h00, v.bus[7:0]}, "R8 type byte", rdata_o, {8'h00, v.bus[7:0]});
        else        chk(rdata_o == v.bus, "R7 rdata", rdata_o, v.bus);
      end
      ready_i = 0;
    end
    @(negedge clk);
    chk_idle("R2 idle after");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5 chk_idle("R1 in reset");
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk_idle("R1 after reset");
    @(negedge clk);
    chk_idle("R2 no request stays idle");

    for (int i = 0; i < NV; i++) run_txn(VEC[i]);

    // R10: request held through T4
    @(negedge clk);
    req_i = 1; req_write_i = 0; req_io_i = 0; req_inta_i = 0; req_bhe_n_i = 0;
    req_addr_i = 20'h12344; ad_i = 16'h9999; ready_i = 1;
    @(negedge clk); // T1
    @(negedge clk); // T2
    @(negedge clk); // T3
    @(negedge clk); // T4
    chk(done_o == 1'b1, "R10 first done", done_o, 1);
    chk(req_ack_o == 1'b1, "R10 ack in T4", req_ack_o, 1);
    @(negedge clk);
    chk(ale_o == 1'b1, "R10 direct T1", ale_o, 1);
    req_i = 0;
    repeat (4) @(negedge clk);
    chk_idle("R10 idle after");

    // R11: reset in the middle of a waited write
    req_i = 1; req_write_i = 1; req_addr_i = 20'h0ABC0; req_wdata_i = 16'hA5A5; ready_i = 0;
    @(negedge clk); // T1
    req_i = 0;
    @(negedge clk); // T2
    @(negedge clk); // T3
    chk(wr_n_o == 1'b0, "R11 write active", wr_n_o, 0);
    rst_ni = 0;
    #1 chk_idle("R11 async return");
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk_idle("R11 stays idle");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule